// File: doc/BRIEF.md
# Chained DMA Channel Engine

A single DMA channel that moves data words between a word-addressed internal memory port and a 16-bit external port. The core writes a descriptor and pulses a start line. From then on the engine runs by itself. It walks the memory with a start index and a signed stride, counts words down, and paces every external beat with a request/grant handshake. When a descriptor is used up, it raises a one-cycle completion interrupt. With chaining on, it fetches the next descriptor from memory and carries on without help.

Internal memory words are 48 bits wide. The external side always carries 16-bit beats, and a mode selects how many beats make up one memory word: one, two or three. The direction bit chooses between packing external beats into memory words (receive) and unpacking memory words into external beats (transmit). The memory port uses a same-cycle read model. Arbitration among channels and real memory timing are outside the scope of this block.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `irq`, `ext_gnt`, `mem_we` and `mem_re` are all low. A `start` pulse while idle captures `cfg_dir`, `cfg_mode`, `cfg_chain`, `cfg_index`, `cfg_modify`, `cfg_count` and `cfg_next`, and `busy` rises on the next clock. A `start` while busy is ignored and has no effect on the transfer in progress.
- R2: `ext_gnt` is high only in a cycle where `ext_req` is high, and each grant cycle moves exactly one 16-bit beat. When `ext_req` is low, the transfer stalls and no progress is lost.
- R3: Receive (`cfg_dir`=0) packs beats least significant first. `cfg_mode`=0 takes one beat per word, 1 takes two, and 2 (or 3) takes three. Bits [15:0] come from the first beat, [31:16] from the second and [47:32] from the third. Bits not filled are written as zero. `mem_we` pulses with the last beat of each word.
- R4: Transmit (`cfg_dir`=1) reads the word at the current index and drives its 16-bit slices on `ext_dout` during the grant cycles, least significant first, using the same beat counts as R3. `mem_we` stays low.
- R5: Word k of a descriptor goes to address index + k*modify, modulo 2^AW. Memory locations outside these addresses are not written.
- R6: A descriptor moves exactly `count` words. A count of zero completes at once: no grant, no memory write, one interrupt.
- R7: `irq` is a single-cycle pulse, issued once for each completed descriptor. In the cycle of the final pulse, `busy` is already low.
- R8: With chaining on and a nonzero next pointer P, the engine reads index from P, modify from P+1, count from P+2 and next from P+3 (low AW bits of each word), then runs that descriptor. A next pointer of zero ends the chain. With chaining off, the next pointer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse from the core |
| cfg_dir | input | 1 | 0 = receive into memory, 1 = transmit from memory |
| cfg_mode | input | 2 | Beats per word: 0 one, 1 two, 2/3 three |
| cfg_chain | input | 1 | Enable descriptor chaining |
| cfg_index | input | AW | Start address |
| cfg_modify | input | AW | Stride added after each word |
| cfg_count | input | AW | Number of words |
| cfg_next | input | AW | Next descriptor pointer, 0 ends |
| busy | output | 1 | Channel active |
| irq | output | 1 | Completion pulse |
| ext_req | input | 1 | External request |
| ext_gnt | output | 1 | External grant, one per beat |
| ext_din | input | 16 | Receive beat |
| ext_dout | output | 16 | Transmit beat |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 48 | Memory write data |
| mem_rdata | input | 48 | Memory read data, same cycle |

## Verification
The bench sweeps every beat mode in both directions, with increasing and wrapping negative strides, under a steady request and a ragged one. It rebuilds the whole memory image and the transmit beat stream in arithmetic. A wrong beat order or a missing zero fill shows up as mismatched upper slices. A stall that drops progress shows up as skipped or repeated beats under the ragged request. A stride error lands words at the wrong addresses, and the full-memory compare catches any write outside the expected addresses.

The chain runs include a zero-count descriptor in the middle. They also cover a run with chaining off but a nonzero next pointer, and a second start issued while busy. A design that moves a word on a zero count, miscounts interrupts, follows the pointer when chaining is off, or accepts the second start would write unexpected addresses or get the grant or interrupt totals wrong.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int AW = 16,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_dir,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_chain,
  input  logic [AW-1:0] cfg_index,
  input  logic [AW-1:0] cfg_modify,
  input  logic [AW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_next,
  output logic          busy,
  output logic          irq,
  input  logic          ext_req,
  output logic          ext_gnt,
  input  logic [BW-1:0] ext_din,
  output logic [BW-1:0] ext_dout,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [3*BW-1:0] mem_wdata,
  input  logic [3*BW-1:0] mem_rdata
);
  localparam int DW = 3 * BW;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FETCH} st_t;

  st_t           st;
  logic [AW-1:0] idx, mdf, cnt, nxt;
  logic          dir_q, chain_q;
  logic [1:0]    mode_q, beat, fi;
  logic [DW-1:0] acc;

  logic [1:0] last_idx;
  logic       last_beat, active;

  assign last_idx  = (mode_q == 2'd0) ? 2'd0 : (mode_q == 2'd1) ? 2'd1 : 2'd2;
  assign last_beat = (beat == last_idx);
  assign active    = (st == S_XFER) && (cnt != '0);

  assign busy      = (st != S_IDLE);
  assign ext_gnt   = active && ext_req;
  assign mem_addr  = (st == S_FETCH) ? nxt + AW'(fi) : idx;
  assign mem_re    = (st == S_FETCH) || (active && dir_q);
  assign mem_we    = ext_gnt && !dir_q && last_beat;
  assign mem_wdata = acc | (DW'(ext_din) << (BW * beat));
  assign ext_dout  = mem_rdata[BW*beat +: BW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      mdf     <= '0;
      cnt     <= '0;
      nxt     <= '0;
      dir_q   <= 1'b0;
      chain_q <= 1'b0;
      mode_q  <= 2'd0;
      beat    <= 2'd0;
      fi      <= 2'd0;
      acc     <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          idx     <= cfg_index;
          mdf     <= cfg_modify;
          cnt     <= cfg_count;
          nxt     <= cfg_next;
          dir_q   <= cfg_dir;
          chain_q <= cfg_chain;
          mode_q  <= cfg_mode;
          beat    <= 2'd0;
          acc     <= '0;
          st      <= S_XFER;
        end
        S_XFER: begin
          if (cnt == '0) begin
            irq <= 1'b1;
            fi  <= 2'd0;
            st  <= (chain_q && nxt != '0) ? S_FETCH : S_IDLE;
          end else if (ext_req) begin
            if (last_beat) begin
              beat <= 2'd0;
              acc  <= '0;
              idx  <= idx + mdf;
              cnt  <= cnt - AW'(1);
            end else begin
              beat <= beat + 2'd1;
              acc  <= mem_wdata;
            end
          end
        end
        S_FETCH: begin
          unique case (fi)
            2'd0: idx <= mem_rdata[AW-1:0];
            2'd1: mdf <= mem_rdata[AW-1:0];
            2'd2: cnt <= mem_rdata[AW-1:0];
            default: begin
              nxt  <= mem_rdata[AW-1:0];
              beat <= 2'd0;
              acc  <= '0;
              st   <= S_XFER;
            end
          endcase
          fi <= fi + 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(dir_q) && $stable(mode_q) && $stable(chain_q)));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ext_req) |=> ($stable(idx) && $stable(cnt) && $stable(beat)));

  // R4
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R5
  stride_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_gnt && last_beat) |=> (idx == $past(idx) + $past(mdf)));

  // R6
  zero_count_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && cnt == '0) |-> (!ext_gnt && !mem_we));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: tb/dma_chain_engine_tb_top.sv
`timescale 1ns/1ps
module dma_chain_engine_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        cfg_dir = 0;
  logic [1:0]  cfg_mode = 0;
  logic        cfg_chain = 0;
  logic [15:0] cfg_index = 0, cfg_modify = 0, cfg_count = 0, cfg_next = 0;
  logic        busy, irq, ext_gnt, mem_re, mem_we;
  logic        ext_req = 0;
  logic [15:0] ext_din, ext_dout, mem_addr;
  logic [47:0] mem_wdata, mem_rdata;

  logic [47:0] mem [64];
  logic [47:0] expm [64];
  logic [15:0] glog [2048];
  logic [15:0] elog [2048];
  int gcnt = 0, irq_cnt = 0, total = 0, bad = 0, cyc = 0;
  bit rnd = 0;
  logic [7:0] lfsr = 8'h5B;

  always #2 clk = ~clk;

  dma_chain_engine #(.AW(16), .BW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dir(cfg_dir), .cfg_mode(cfg_mode),
    .cfg_chain(cfg_chain), .cfg_index(cfg_index), .cfg_modify(cfg_modify),
    .cfg_count(cfg_count), .cfg_next(cfg_next), .busy(busy), .irq(irq),
    .ext_req(ext_req), .ext_gnt(ext_gnt), .ext_din(ext_din), .ext_dout(ext_dout),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  function automatic logic [15:0] bval(int n);
    return 16'hA000 ^ 16'(n * 311);
  endfunction

  assign mem_rdata = mem[mem_addr[5:0]];
  assign ext_din   = bval(gcnt);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    if (ext_gnt) begin
      if (gcnt < 2048) glog[gcnt] <= ext_dout;
      gcnt <= gcnt + 1;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ext_req = rnd ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) if (cyc > 150000) begin
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exv);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 64; i++) mem[i] = 48'h5A5A_0000_0000 + 48'(i) * 48'h0001_0003_0007;
    mem[48] = 48'd10; mem[49] = 48'd2; mem[50] = 48'd3; mem[51] = 48'd52;
    mem[52] = 48'd40; mem[53] = 48'd1; mem[54] = 48'd0; mem[55] = 48'd56;
    mem[56] = 48'd33; mem[57] = 48'd1; mem[58] = 48'd1; mem[59] = 48'd0;
  endtask

  task automatic run(input bit dir, input logic [1:0] mode, input bit chain,
                     input logic [15:0] idx, input logic [15:0] mdf, input logic [15:0] cnt,
                     input logic [15:0] nxt, input bit rq, input bit poke, input string tag);
    int g, nirq, nb, gb, ib, t, mis;
    logic [15:0] i_, m_, c_, n_, ad;
    logic [47:0] v;
    init_mem();
    for (int i = 0; i < 64; i++) expm[i] = mem[i];
    nb = (mode == 0) ? 1 : (mode == 1) ? 2 : 3;
    gb = gcnt; ib = irq_cnt; g = 0; nirq = 0;
    i_ = idx; m_ = mdf; c_ = cnt; n_ = nxt;
    for (int d = 0; d < 8; d++) begin
      for (int w = 0; w < int'(c_); w++) begin
        ad = i_ + 16'(w) * m_;
        if (!dir) begin
          v = '0;
          for (int j = 0; j < nb; j++) begin v[16*j +: 16] = bval(gb + g); g++; end
          expm[ad[5:0]] = v;
        end else begin
          for (int j = 0; j < nb; j++) begin elog[g] = expm[ad[5:0]][16*j +: 16]; g++; end
        end
      end
      nirq++;
      if (!chain || n_ == 0) break;
      i_ = expm[n_[5:0]][15:0];
      m_ = expm[n_[5:0] + 6'd1][15:0];
      c_ = expm[n_[5:0] + 6'd2][15:0];
      n_ = expm[n_[5:0] + 6'd3][15:0];
    end
    rnd = rq;
    @(negedge clk);
    cfg_dir = dir; cfg_mode = mode; cfg_chain = chain;
    cfg_index = idx; cfg_modify = mdf; cfg_count = cnt; cfg_next = nxt;
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      cfg_dir = ~dir; cfg_mode = 2'd0; cfg_index = 16'd45; cfg_count = 16'd2; cfg_chain = 1;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
    check(t < 3000, {tag, " R1 run ends"}, 64'(t), 64'd3000);
    @(posedge clk); @(negedge clk);
    // R7 / R8: one interrupt per descriptor walked
    check(irq_cnt - ib == nirq, {tag, " R7 R8 irq count"}, 64'(irq_cnt - ib), 64'(nirq));
    // R2 / R6: grant total equals words times beats
    check(gcnt - gb == g, {tag, " R2 R6 grant count"}, 64'(gcnt - gb), 64'(g));
    // R3 / R5: whole memory image
    mis = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== expm[i]) begin
      if (mis == 0) check(0, {tag, " R3 R5 memory word"}, 64'(mem[i]), 64'(expm[i]));
      mis++;
    end
    if (mis == 0) check(1, {tag, " R3 R5 memory"}, 0, 0);
    if (dir) begin
      mis = 0;
      for (int k = 0; k < g; k++) if (glog[gb + k] !== elog[k]) begin
        if (mis == 0) check(0, {tag, " R4 transmit beat"}, 64'(glog[gb + k]), 64'(elog[k]));
        mis++;
      end
      if (mis == 0) check(1, {tag, " R4 transmit"}, 0, 0);
    end
  endtask

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, irq, ext_gnt, mem_we, mem_re} == 5'b0, "R1 reset outputs",
          64'({busy, irq, ext_gnt, mem_we, mem_re}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && !irq, "R1 idle after reset", 64'({busy, irq}), 0);
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 3; m++)
        for (int r = 0; r < 2; r++)
          for (int s = 0; s < 2; s++) begin
            if (s == 0) run(d[0], m[1:0], 0, 16'd4, 16'd1, 16'd3, 16'd0, r[0], 0, "sweep up");
            else        run(d[0], m[1:0], 0, 16'd30, 16'hFFFD, 16'd4, 16'd0, r[0], 0, "sweep down");
          end
    run(0, 2'd3, 0, 16'd7, 16'd5, 16'd2, 16'd0, 1, 0, "R3 mode3");
    run(0, 2'd1, 0, 16'd5, 16'd1, 16'd0, 16'd0, 0, 0, "R6 zero count");
    run(0, 2'd2, 1, 16'd0, 16'd1, 16'd2, 16'd48, 1, 0, "R8 chain rx");
    run(1, 2'd1, 1, 16'd20, 16'd3, 16'd2, 16'd48, 0, 0, "R8 chain tx");
    run(0, 2'd0, 0, 16'd0, 16'd1, 16'd2, 16'd48, 0, 0, "R8 chain off");
    run(0, 2'd2, 0, 16'd12, 16'd2, 16'd5, 16'd0, 0, 1, "R1 start while busy");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule